// File: doc/BRIEF.md
# Fractal Decode Range Mapper

This block carries out one decode pass for a single range block of a fractally coded 64x64 image with 8-bit grey pixels. A controller gives it a start pulse with the range position and size, the position of the matching domain block, a 3-bit orientation code, a 4-bit contrast code and a 7-bit brightness code. The domain block has twice the side length of the range. The block reads that domain from a source pixel memory and shrinks it by averaging each non-overlapping 2x2 group. It scales every shrunk pixel by the contrast, adds the brightness, clamps the result to 0..255 and writes it into the range's place in a destination pixel memory, with the placement reoriented by the code. A one-cycle done pulse ends the pass.

The block only reads the source memory and only writes the destination memory, so successive iterations can swap the two memories. The source port is a plain synchronous read with one cycle of latency. The destination side is a valid/ready stream of address and data. While `wr_valid` is high and `wr_ready` is low, the block holds address and data steady, issues no new reads and waits. A beat is transferred on a rising edge where both are high. The consumer may hold `wr_ready` low for as long as it needs.

Top module: `fractal_range_mapper`

## Requirements
- R1: After reset `busy`, `done`, `wr_valid` and `rd_en` are all low.
- R2: Each output pixel costs exactly four source reads, at the 2x2 group (2i+a, 2j+b) of the domain with a,b in {0,1}. Address = row*64 + col, and rows and columns wrap modulo 64. Read data is taken one cycle after `rd_en`.
- R3: The shrunk pixel is the 10-bit sum of its four source pixels shifted right by two, discarding the remainder.
- R4: The contrast code is a two's-complement value q in -8..7 meaning q/8. The product avg*q is rounded as floor((avg*q + 4)/8).
- R5: The brightness code o adds 2*o. The sum is clamped to 0..255.
- R6: For a range of side N, orientation code {m, r1, r0} sends shrunk pixel (row i, col j) to range cell: 0:(i,j) 1:(j,N-1-i) 2:(N-1-i,N-1-j) 3:(N-1-j,i) 4:(i,N-1-j) 5:(N-1-j,N-1-i) 6:(N-1-i,j) 7:(j,i). Bit m mirrors columns first, then r1r0 rotates clockwise by that many quarter turns.
- R7: A pass writes exactly N*N beats, one per shrunk pixel, in raster order of the shrunk pixel (i major, j minor). The size code k in 2..4 gives N = 2^k.
- R8: While `wr_valid` is high and `wr_ready` low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged and `rd_en` stays low.
- R9: `done` is high for exactly one cycle, the cycle after the last beat is accepted. `busy` is low in that cycle and after it.
- R10: A start pulse while busy is ignored and launches no further pass.
- R11: All pass parameters are captured on start. Changing the inputs during a pass has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken when idle |
| size_lg | input | 3 | Range side as log2, 2..4 |
| rng_row | input | 6 | Range top row in destination |
| rng_col | input | 6 | Range left column in destination |
| dom_row | input | 6 | Domain top row in source |
| dom_col | input | 6 | Domain left column in source |
| orient | input | 3 | Orientation code (R6) |
| contrast | input | 4 | Signed contrast code (R4) |
| bright | input | 7 | Brightness code (R5) |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| rd_en | output | 1 | Source read strobe |
| rd_addr | output | 12 | Source read address |
| rd_data | input | 8 | Source read data, one cycle latency |
| wr_valid | output | 1 | Destination beat valid |
| wr_ready | input | 1 | Destination ready |
| wr_addr | output | 12 | Destination address |
| wr_data | output | 8 | Destination pixel |

## Verification
A wrong position counter or orientation select puts a beat at a wrong destination address. That shows up in the beat log at the first misplaced beat, which is within the first N beats for most faults. A faulty accumulator clear or read-capture phase corrupts the very first pixel's value. A broken stall path changes the address or data under a held valid in the same cycle. A bad end condition gives a wrong beat count, or a missing or doubled done pulse, at the end of the pass.

// File: rtl/frm_pkg.sv
package frm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_READ = 3'd1,
    ST_LAST = 3'd2,
    ST_PUSH = 3'd3,
    ST_FIN  = 3'd4
  } frm_state_t;

  typedef struct packed {
    logic [2:0] lg;
    logic [5:0] rrow;
    logic [5:0] rcol;
    logic [5:0] drow;
    logic [5:0] dcol;
    logic [2:0] orient;
    logic [3:0] s;
    logic [6:0] o;
  } frm_job_t;
endpackage

// File: rtl/frm_orient.sv
module frm_orient #(
  parameter int CW = 4
) (
  input  logic [CW-1:0] i,
  input  logic [CW-1:0] j,
  input  logic [CW-1:0] nmask,
  input  logic [2:0]    code,
  output logic [CW-1:0] row,
  output logic [CW-1:0] col
);
  logic [CW-1:0] jm;
  logic [CW-1:0] ni;
  logic [CW-1:0] njm;

  always_comb begin
    jm  = code[2] ? (nmask - j) : j;
    ni  = nmask - i;
    njm = nmask - jm;
    unique case (code[1:0])
      2'd0: begin row = i;   col = jm;  end
      2'd1: begin row = jm;  col = ni;  end
      2'd2: begin row = ni;  col = njm; end
      default: begin row = njm; col = i; end
    endcase
  end
endmodule

// File: rtl/frm_pixel_math.sv
module frm_pixel_math #(
  parameter int PIX_W = 8,
  parameter int S_W   = 4,
  parameter int O_W   = 7
) (
  input  logic [PIX_W+1:0] sum,
  input  logic [S_W-1:0]   s_code,
  input  logic [O_W-1:0]   o_code,
  output logic [PIX_W-1:0] pix
);
  localparam int FB   = S_W - 1;
  localparam int AW   = PIX_W + 3;
  localparam int PW   = AW + S_W;
  localparam int RND  = 1 << (FB - 1);
  localparam int MAXV = (1 << PIX_W) - 1;
  localparam int OSH  = PIX_W - O_W;

  logic signed [AW-1:0] avg_s;
  logic signed [S_W-1:0] s_s;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic signed [PW-1:0] ofs;
  logic signed [PW-1:0] tot;

  always_comb begin
    avg_s = $signed({1'b0, sum >> 2});
    s_s   = $signed(s_code);
    prod  = avg_s * s_s;
    rnd   = (prod + $signed(PW'(RND))) >>> FB;
    ofs   = $signed(PW'({o_code, {OSH{1'b0}}}));
    tot   = rnd + ofs;
    if (tot < 0)
      pix = '0;
    else if (tot > $signed(PW'(MAXV)))
      pix = PIX_W'(MAXV);
    else
      pix = tot[PIX_W-1:0];
  end
endmodule

// File: rtl/fractal_range_mapper.sv
module fractal_range_mapper
  import frm_pkg::*;
#(
  parameter int IMG_DIM = 64,
  parameter int PIX_W   = 8,
  parameter int MAX_LG  = 4,
  parameter int S_W     = 4,
  parameter int O_W     = 7
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [2:0]                     size_lg,
  input  logic [$clog2(IMG_DIM)-1:0]     rng_row,
  input  logic [$clog2(IMG_DIM)-1:0]     rng_col,
  input  logic [$clog2(IMG_DIM)-1:0]     dom_row,
  input  logic [$clog2(IMG_DIM)-1:0]     dom_col,
  input  logic [2:0]                     orient,
  input  logic [S_W-1:0]                 contrast,
  input  logic [O_W-1:0]                 bright,
  output logic                           busy,
  output logic                           done,
  output logic                           rd_en,
  output logic [2*$clog2(IMG_DIM)-1:0]   rd_addr,
  input  logic [PIX_W-1:0]               rd_data,
  output logic                           wr_valid,
  input  logic                           wr_ready,
  output logic [2*$clog2(IMG_DIM)-1:0]   wr_addr,
  output logic [PIX_W-1:0]               wr_data
);
  localparam int RW = $clog2(IMG_DIM);
  localparam int CW = MAX_LG;
  localparam int SUMW = PIX_W + 2;

  frm_state_t state;
  logic [2:0]     p_lg;
  logic [RW-1:0]  p_rr, p_rc, p_dr, p_dc;
  logic [2:0]     p_or;
  logic [S_W-1:0] p_s;
  logic [O_W-1:0] p_o;
  logic [CW-1:0]  ci, cj;
  logic [1:0]     kq;
  logic           rd_vld;
  logic [SUMW-1:0] sum;
  logic [CW-1:0]  nmask;
  logic           last_px;
  logic [CW-1:0]  orow, ocol;
  logic [RW-1:0]  src_r, src_c, dst_r, dst_c;

  assign nmask   = ~({CW{1'b1}} << p_lg);
  assign last_px = (ci == nmask) && (cj == nmask);

  // source 2x2 group address
  assign src_r   = p_dr + RW'({ci, 1'b0}) + RW'(kq[1]);
  assign src_c   = p_dc + RW'({cj, 1'b0}) + RW'(kq[0]);
  assign rd_addr = {src_r, src_c};
  assign rd_en   = (state == ST_READ);

  frm_orient #(.CW(CW)) u_orient (
    .i(ci), .j(cj), .nmask(nmask), .code(p_or), .row(orow), .col(ocol)
  );

  frm_pixel_math #(.PIX_W(PIX_W), .S_W(S_W), .O_W(O_W)) u_math (
    .sum(sum), .s_code(p_s), .o_code(p_o), .pix(wr_data)
  );

  assign dst_r    = p_rr + RW'(orow);
  assign dst_c    = p_rc + RW'(ocol);
  assign wr_addr  = {dst_r, dst_c};
  assign wr_valid = (state == ST_PUSH);
  assign done     = (state == ST_FIN);
  assign busy     = (state != ST_IDLE) && (state != ST_FIN);

  // accumulator: cleared on first read of a group, adds each returning pixel
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld <= 1'b0;
      sum    <= '0;
    end else begin
      rd_vld <= rd_en;
      sum    <= ((state == ST_READ && kq == 2'd0) ? '0 : sum)
              + (rd_vld ? SUMW'(rd_data) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ci <= '0; cj <= '0; kq <= '0;
      p_lg <= '0; p_rr <= '0; p_rc <= '0; p_dr <= '0; p_dc <= '0;
      p_or <= '0; p_s <= '0; p_o <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          p_lg <= size_lg; p_rr <= rng_row; p_rc <= rng_col;
          p_dr <= dom_row; p_dc <= dom_col; p_or <= orient;
          p_s  <= contrast; p_o <= bright;
          ci <= '0; cj <= '0; kq <= '0;
          state <= ST_READ;
        end
        ST_READ: begin
          kq <= kq + 2'd1;
          if (kq == 2'd3) state <= ST_LAST;
        end
        ST_LAST: state <= ST_PUSH;
        ST_PUSH: if (wr_ready) begin
          if (last_px) begin
            state <= ST_FIN;
          end else begin
            state <= ST_READ;
            kq <= '0;
            if (cj == nmask) begin
              cj <= '0;
              ci <= ci + 1'b1;
            end else begin
              cj <= cj + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: held beat under back-pressure
  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  // R8: no reads while a beat is pending
  a_r8_no_read_wait: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_en);
  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);
  // R9: done follows an accepted beat
  a_r9_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(wr_valid && wr_ready));
  // R10 / R11: captured job unchanged while running
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(p_s) && $stable(p_or) && $stable(p_dr) && $stable(p_rr));
  // R1: idle block drives nothing
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_en && !wr_valid);
endmodule

// File: tb/tb_fractal_range_mapper.sv
`timescale 1ns/1ps
module tb_fractal_range_mapper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] size_lg = '0;
  logic [5:0] rng_row = '0, rng_col = '0, dom_row = '0, dom_col = '0;
  logic [2:0] orient = '0;
  logic [3:0] contrast = '0;
  logic [6:0] bright = '0;
  logic busy, done, rd_en, wr_valid;
  logic wr_ready = 1'b1;
  logic [11:0] rd_addr, wr_addr;
  logic [7:0] rd_data = '0, wr_data;

  always #2.5 clk = ~clk;

  fractal_range_mapper dut (
    .clk(clk), .rst_n(rst_n), .start(start), .size_lg(size_lg),
    .rng_row(rng_row), .rng_col(rng_col), .dom_row(dom_row), .dom_col(dom_col),
    .orient(orient), .contrast(contrast), .bright(bright),
    .busy(busy), .done(done), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] smem [4096];
  logic [7:0] dmem [4096];
  int wlog [256];
  int wr_cnt = 0, rd_cnt = 0, done_cnt = 0, hold_bad = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic prev_stall = 1'b0;
  logic [11:0] prev_addr = '0;
  logic [7:0] prev_data = '0;

  // source memory, one-cycle read latency
  always @(posedge clk) if (rd_en) rd_data <= smem[rd_addr];

  always @(posedge clk) begin
    if (rd_en) rd_cnt <= rd_cnt + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (wr_valid && wr_ready) begin
      dmem[wr_addr] <= wr_data;
      if (wr_cnt < 256) wlog[wr_cnt] <= int'(wr_addr);
      wr_cnt <= wr_cnt + 1;
    end
    if (prev_stall && (!wr_valid || wr_addr != prev_addr || wr_data != prev_data || rd_en))
      hold_bad <= hold_bad + 1;
    prev_stall <= wr_valid && !wr_ready;
    prev_addr  <= wr_addr;
    prev_data  <= wr_data;
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready <= (ready_mode == 0) ? 1'b1 : (lfsr[3] & ~lfsr[7]) | lfsr[0];
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill_src(input int mode);
    for (int a = 0; a < 4096; a++)
      smem[a] = (mode == 1) ? 8'd255 : 8'((a * 37 + (a >> 6) * 11 + (a >> 3)) & 255);
  endtask

  function automatic int model_pix(input int sm, input int q, input int o);
    int avg, p, v;
    avg = sm / 4;
    p = avg * q + 4;
    v = (p >>> 3) + 2 * o;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  task automatic place(input int code, input int n, input int i, input int j,
                       output int r, output int c);
    case (code)
      0: begin r = i;         c = j;         end
      1: begin r = j;         c = n - 1 - i; end
      2: begin r = n - 1 - i; c = n - 1 - j; end
      3: begin r = n - 1 - j; c = i;         end
      4: begin r = i;         c = n - 1 - j; end
      5: begin r = n - 1 - j; c = n - 1 - i; end
      6: begin r = n - 1 - i; c = j;         end
      default: begin r = j;   c = i;         end
    endcase
  endtask

  // disturb: 0 none, 1 second start while busy, 2 inputs changed mid-pass
  task automatic run_pass(input string tag, input int lg, input int rr, input int rc,
                          input int dr, input int dc, input int oc, input int q,
                          input int o, input int rmode, input int disturb);
    int n, bad_d, bad_o, first_a, first_v, first_e, r, c, sm, da, exp_v;
    n = 1 << lg;
    ready_mode = rmode;
    for (int a = 0; a < 4096; a++) dmem[a] = 8'h5A;
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; done_cnt = 0; hold_bad = 0;
    size_lg = 3'(lg); rng_row = 6'(rr); rng_col = 6'(rc); dom_row = 6'(dr); dom_col = 6'(dc);
    orient = 3'(oc); contrast = 4'(q); bright = 7'(o); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (disturb != 0) begin
      repeat (10) @(negedge clk);
      contrast = 4'(q + 3); bright = 7'(o + 40); orient = 3'(oc + 1);
      dom_row = 6'(dr + 5); rng_col = 6'(rc + 2);
      if (disturb == 1) begin start = 1'b1; @(negedge clk); start = 1'b0; end
    end
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    bad_d = 0; bad_o = 0; first_a = 0; first_v = 0; first_e = 0;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < n; j++) begin
        sm = 0;
        for (int a = 0; a < 2; a++)
          for (int b = 0; b < 2; b++)
            sm += int'(smem[((dr + 2*i + a) & 63) * 64 + ((dc + 2*j + b) & 63)]);
        place(oc, n, i, j, r, c);
        da = ((rr + r) & 63) * 64 + ((rc + c) & 63);
        exp_v = model_pix(sm, (q >= 8) ? q - 16 : q, o);
        if (int'(dmem[da]) != exp_v) begin
          if (bad_d == 0) begin first_a = da; first_v = int'(dmem[da]); first_e = exp_v; end
          bad_d++;
        end
        if (wlog[i*n + j] != da) bad_o++;
      end
    if (bad_d != 0) $display("  %s pixel at %0d: got %0d want %0d", tag, first_a, first_v, first_e);
    chk({tag, " pixel values"}, bad_d, 0);
    chk("R7 beat count", wr_cnt, n * n);
    chk("R7 raster order and placement", bad_o, 0);
    chk("R2 four reads per pixel", rd_cnt, 4 * n * n);
    chk("R9 single done pulse", done_cnt, 1);
    chk("R9 busy low after done", int'(busy), 0);
    chk("R8 stall hold", hold_bad, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 wr_valid", int'(wr_valid), 0);
    chk("R1 rd_en", int'(rd_en), 0);
  endtask

  task automatic t_average(); fill_src(0); run_pass("R3", 2, 8, 4, 20, 10, 0, 4, 10, 0, 0); endtask
  task automatic t_orients();
    fill_src(0);
    for (int oc = 0; oc < 8; oc++) run_pass("R6", 2, 12, 30, 3, 41, oc, 5, 20, 0, 0);
  endtask
  task automatic t_negative(); fill_src(0); run_pass("R4", 3, 0, 0, 16, 16, 2, 8, 64, 0, 0); endtask
  task automatic t_clamp_hi(); fill_src(1); run_pass("R5", 4, 32, 40, 0, 0, 3, 7, 127, 0, 0); endtask
  task automatic t_clamp_lo(); fill_src(0); run_pass("R5", 2, 60, 60, 58, 60, 7, 9, 3, 0, 0); endtask
  task automatic t_backpressure(); fill_src(0); run_pass("R8", 3, 5, 50, 40, 22, 5, 3, 33, 1, 0); endtask
  task automatic t_busy_start(); fill_src(0); run_pass("R10", 3, 10, 10, 30, 2, 1, 6, 15, 0, 1); endtask
  task automatic t_capture(); fill_src(0); run_pass("R11", 4, 20, 8, 17, 33, 6, 12, 90, 1, 2); endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_average();
        t_orients();
        t_negative();
        t_clamp_hi();
        t_clamp_lo();
        t_backpressure();
        t_busy_start();
        t_capture();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule